// File: doc/BRIEF.md
# Link-Side Status Sender

This block sits in the physical layer and carries status information to the link layer over a two-bit data bus. While a transfer is in progress it drives the status code on a two-bit control output. There are two kinds of transfer. A short one carries only the pending flag bits. A long one carries the flags followed by a register address and the register contents. A long transfer is used to answer a register read request, and also to deliver the node-identity register once the self-identification phase is over.

A transfer starts only when the interface is reported idle. It then shifts out two bits on every clock. If a packet reception begins, the transfer is cut off at once. Flag bits count as delivered in the cycle they appear on the bus, so a flag pair that was not reached stays pending. Register contents are different: they are sent again from the first pair until one long transfer runs to its end. The block holds a single register slot. A read request that arrives while that slot is occupied is dropped. A self-identification result is parked until the slot is free.

Top module: `status_tx`

## Requirements
- R1: After reset, and in any cycle in which a transfer has not been started, ctl is 00 and d is 00. A transfer begins only in the cycle after one in which bus_idle was high, rx_preempt was low and something was pending.
- R2: Every cycle of a transfer drives ctl = 01. Pair k (k = 0, 1, ...) of the transfer word is driven on the k-th cycle, with word bit 2k on d[0] and word bit 2k+1 on d[1].
- R3: When no register content is pending, the transfer is short: two cycles carrying word bits 3:0, which are the pending flags.
- R4: When register content is pending, the transfer is long: eight cycles carrying word bits 3:0 = flags, bits 7:4 = register address, bits 15:8 = register data.
- R5: In any cycle in which rx_preempt is high, ctl and d are both 00. A transfer in progress ends in that cycle.
- R6: Register content stays pending after an aborted transfer and is sent again from pair 0. It is cleared only when a long transfer completes all eight pairs.
- R7: A flag bit is cleared once its pair has been driven. Flags whose pair was not driven stay pending. New flag_set bits are ORed into the pending flags, so several pulses merge into one transfer.
- R8: Consecutive transfers are separated by at least one cycle with ctl = 00. No run of ctl = 01 is longer than eight cycles.
- R9: A rd_req that arrives while register content is already pending is ignored.
- R10: selfid_done schedules a long transfer with address SELFID_ADDR (default 0) and data phy_id. If rd_req arrives in the same cycle, the read is served first and the self-ID transfer follows.
- R11: ctl only ever takes the values 00 (idle) and 01 (status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set | input | FLAG_W | One-cycle pulses that raise status flags |
| rd_req | input | 1 | Register read request, qualifies rd_addr and rd_data |
| rd_addr | input | ADDR_W | Address of the register that was read |
| rd_data | input | DATA_W | Contents of the register that was read |
| selfid_done | input | 1 | Pulse marking the end of self-identification |
| phy_id | input | DATA_W | Node-identity register value, captured on selfid_done |
| bus_idle | input | 1 | High when the interface is free for a status transfer |
| rx_preempt | input | 1 | High while a packet reception takes over the interface |
| ctl | output | 2 | Control code: 00 idle, 01 status |
| d | output | 2 | Status data pair |

## Verification
The sender is tried with four kinds of input:
- A lone flag pulse, and flag pulses that merge, show that a short transfer carries exactly the flag nibble in pair order.
- Read requests with different addresses and data confirm where the address and data fields sit in the long word.
- Cutting a long transfer after one pair and after three pairs separates register retry from flag delivery. The retried word must keep only the flags that were never driven.
- A second read while the slot is busy, a self-ID landing together with a read, and a read raised during a short transfer expose the ignore rule, the slot ordering and the idle gap between runs.

// File: rtl/status_tx.sv
module status_tx #(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SELFID_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              selfid_done,
  input  logic [DATA_W-1:0] phy_id,
  input  logic              bus_idle,
  input  logic              rx_preempt,
  output logic [1:0]        ctl,
  output logic [1:0]        d
);
  localparam int WORD_W = FLAG_W + ADDR_W + DATA_W;
  localparam int PAIRS  = WORD_W / 2;
  localparam int SHORT  = FLAG_W / 2;
  localparam int CW     = $clog2(PAIRS);
  localparam logic [CW-1:0] LAST_LONG  = CW'(PAIRS - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT - 1);

  logic              active, is_long;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] word;
  logic [FLAG_W-1:0] flags_q, sent_mask;
  logic              reg_pend, sid_pend;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_data, sid_data;

  wire sending = active && !rx_preempt;
  wire start   = !active && bus_idle && !rx_preempt && (reg_pend || flags_q != '0);
  wire last    = cnt == (is_long ? LAST_LONG : LAST_SHORT);

  assign ctl = sending ? 2'b01 : 2'b00;
  assign d   = sending ? word[{cnt, 1'b0} +: 2] : 2'b00;

  always_comb begin
    sent_mask = '0;
    if (sending && int'(cnt) < SHORT)
      sent_mask = word[FLAG_W-1:0] & (FLAG_W'(3) << (2 * int'(cnt)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_long  <= 1'b0;
      cnt      <= '0;
      word     <= '0;
      flags_q  <= '0;
      reg_pend <= 1'b0;
      sid_pend <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
      sid_data <= '0;
    end else begin
      flags_q <= (flags_q & ~sent_mask) | flag_set;

      if (start) begin
        active  <= 1'b1;
        cnt     <= '0;
        is_long <= reg_pend;
        word    <= {reg_data, reg_addr, flags_q};
      end else if (active) begin
        if (rx_preempt) begin
          active <= 1'b0;
        end else if (last) begin
          active <= 1'b0;
          if (is_long) reg_pend <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      if (!reg_pend) begin
        if (rd_req) begin
          reg_pend <= 1'b1;
          reg_addr <= rd_addr;
          reg_data <= rd_data;
        end else if (sid_pend) begin
          reg_pend <= 1'b1;
          reg_addr <= SELFID_ADDR;
          reg_data <= sid_data;
          sid_pend <= 1'b0;
        end
      end

      if (selfid_done) begin
        sid_pend <= 1'b1;
        sid_data <= phy_id;
      end
    end
  end
endmodule

module status_tx_chk #(
  parameter int RUN_MAX = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl,
  input logic [1:0] d,
  input logic       bus_idle,
  input logic       rx_preempt,
  input logic       reg_pend
);
  int run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else if (ctl == 2'b01) run <= run + 1;
    else run <= 0;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl == 2'b00 || ctl == 2'b01);                                   // R11
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl == 2'b00 |-> d == 2'b00);                                    // R1
  AST_PREEMPT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_preempt |-> ctl == 2'b00);                                    // R5
  AST_START_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 2'b01 && $past(ctl) == 2'b00) |-> $past(bus_idle) && !$past(rx_preempt)); // R1
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl == 2'b01 |-> run < RUN_MAX);                                 // R8
  AST_REG_KEPT_UNTIL_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_pend) |-> $past(ctl) == 2'b01);                        // R6
endmodule

bind status_tx status_tx_chk #(.RUN_MAX(PAIRS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .d(d), .bus_idle(bus_idle),
  .rx_preempt(rx_preempt), .reg_pend(reg_pend)
);

// File: tb/status_tx_tb_top.sv
module status_tx_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, rd_req, selfid_done, bus_idle, rx_preempt;
  logic [3:0] flag_set, rd_addr;
  logic [7:0] rd_data, phy_id;
  logic [1:0] ctl, d;

  status_tx dut_i (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .selfid_done(selfid_done),
    .phy_id(phy_id), .bus_idle(bus_idle), .rx_preempt(rx_preempt),
    .ctl(ctl), .d(d)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_word[$];
  int          exp_len[$];
  string       exp_tag[$];

  logic [15:0] got;
  int          n = 0;

  task automatic expect_xfer(input logic [15:0] w, input int len, input string tag);
    exp_word.push_back(w);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic end_run();
    logic [15:0] mask, w;
    int len;
    string tag;
    if (exp_word.size() == 0) begin
      check(1'b0, "R9 unexpected transfer", got, 16'h0);
      return;
    end
    w = exp_word.pop_front();
    len = exp_len.pop_front();
    tag = exp_tag.pop_front();
    mask = (len >= 8) ? 16'hFFFF : ((16'h1 << (2 * len)) - 16'h1);
    check(n == len, {tag, " length"}, 16'(n), 16'(len));
    check((got & mask) == (w & mask), {tag, " bits"}, got & mask, w & mask);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ctl == 2'b01) begin
        if (n < 8) begin
          got[2*n]   = d[0];
          got[2*n+1] = d[1];
        end
        n++;
      end else begin
        if (ctl != 2'b00 || d != 2'b00)
          check(1'b0, "R11 idle code", {12'h0, ctl, d}, 16'h0);
        if (n > 0) begin
          end_run();
          n = 0;
          got = '0;
        end
      end
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic pulse_flags(input logic [3:0] f);
    flag_set = f; cyc(1); flag_set = '0;
  endtask

  task automatic pulse_rd(input logic [3:0] a, input logic [7:0] v);
    rd_req = 1'b1; rd_addr = a; rd_data = v; cyc(1); rd_req = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_word.size() != 0 || ctl != 2'b00) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (20) @(negedge clk);
    check(exp_word.size() == 0, "scoreboard drained", 16'(exp_word.size()), 16'h0);
    cyc(1);
  endtask

  task automatic preempt_after(input int pairs);
    for (int i = 0; i < pairs; i++) begin
      @(negedge clk);
      while (ctl != 2'b01) @(negedge clk);
    end
    @(posedge clk); #1;
    rx_preempt = 1'b1; bus_idle = 1'b0;
    @(negedge clk);
    check(ctl == 2'b00 && d == 2'b00, "R5 preempt drops status", {12'h0, ctl, d}, 16'h0);
    cyc(3);
    rx_preempt = 1'b0; bus_idle = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; flag_set = '0; rd_req = 1'b0; rd_addr = '0; rd_data = '0;
    selfid_done = 1'b0; phy_id = '0; bus_idle = 1'b1; rx_preempt = 1'b0;
    cyc(4);
    @(negedge clk);
    check(ctl == 2'b00 && d == 2'b00, "R1 reset idle", {12'h0, ctl, d}, 16'h0);
    rst_n = 1'b1;
    cyc(2);

    // R3 / R2: lone flags
    expect_xfer(16'h000A, 2, "R3 short flags");
    pulse_flags(4'b1010);
    drain();

    // R4: register read response
    expect_xfer(16'hC350, 8, "R4 long read");
    pulse_rd(4'h5, 8'hC3);
    drain();

    // R1: held off while bus busy, then while preempt high
    bus_idle = 1'b0;
    pulse_flags(4'b0110);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(ctl == 2'b00, "R1 wait for idle", {14'h0, ctl}, 16'h0);
    end
    cyc(1);
    bus_idle = 1'b1; rx_preempt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(ctl == 2'b00, "R1 no start under preempt", {14'h0, ctl}, 16'h0);
    end
    expect_xfer(16'h0006, 2, "R1 held flags");
    cyc(1);
    rx_preempt = 1'b0;
    drain();

    // R6 / R7: abort after three pairs, flags already delivered
    bus_idle = 1'b0;
    pulse_flags(4'b0011);
    pulse_rd(4'h2, 8'h5A);
    expect_xfer(16'h5A23, 3, "R5 aborted after 3");
    expect_xfer(16'h5A20, 8, "R6 retry without flags");
    cyc(1);
    bus_idle = 1'b1;
    preempt_after(3);
    drain();

    // R6 / R7: abort after one pair, upper flags retained
    bus_idle = 1'b0;
    pulse_flags(4'b1101);
    pulse_rd(4'h9, 8'h3C);
    expect_xfer(16'h3C9D, 1, "R5 aborted after 1");
    expect_xfer(16'h3C9C, 8, "R7 retry keeps unsent flags");
    cyc(1);
    bus_idle = 1'b1;
    preempt_after(1);
    drain();

    // R7: flags accumulate into one transfer
    bus_idle = 1'b0;
    pulse_flags(4'b0001);
    pulse_flags(4'b0100);
    expect_xfer(16'h0005, 2, "R7 merged flags");
    cyc(1);
    bus_idle = 1'b1;
    drain();

    // R9: second read ignored while first pending
    bus_idle = 1'b0;
    pulse_rd(4'h1, 8'h11);
    pulse_rd(4'h2, 8'h22);
    expect_xfer(16'h1110, 8, "R9 first read kept");
    cyc(1);
    bus_idle = 1'b1;
    drain();

    // R10: self-ID and read in the same cycle
    bus_idle = 1'b0;
    selfid_done = 1'b1; phy_id = 8'h47;
    pulse_rd(4'h3, 8'h99);
    selfid_done = 1'b0;
    expect_xfer(16'h9930, 8, "R10 read first");
    expect_xfer(16'h4700, 8, "R10 self-ID register");
    cyc(2);
    bus_idle = 1'b1;
    drain();

    // R8: read raised during a short transfer follows after a gap
    expect_xfer(16'h0001, 2, "R8 first of pair");
    expect_xfer(16'h8160, 8, "R8 second after gap");
    pulse_flags(4'b0001);
    @(negedge clk);
    while (ctl != 2'b01) @(negedge clk);
    cyc(0);
    pulse_rd(4'h6, 8'h81);
    drain();

    finish_run();
  end
endmodule